// File: doc/BRIEF.md
# Bit-Serial Configuration Stream Loader

This block takes a configuration image that software toggles out one bit at a time on three lines of a shared control word. The lines are a serial data line, a configuration clock line and a hold line. The control word comes from an asynchronous register, so the block first passes it through a synchroniser chain. It then watches for rising edges on the configuration clock line and shifts in the serial data, least-significant bit first. Each time eight bits have arrived, it presents the completed byte to a downstream consumer with a single-cycle valid pulse.

A load is framed by the hold line. A low-to-high transition on the hold line opens a new load. If the hold line drops before a byte is complete, the partial byte is thrown away. When the whole control word takes a fixed end value on a byte boundary, the load is finished: a done flag is raised, and a byte counter reports how many bytes were delivered.

Top module: `cfgld_top`

## Requirements
- R1: While reset is asserted and after it is released, `byte_valid_o`, `byte_data_o`, `byte_count_o` and `load_done_o` are all zero until the control word causes an event.
- R2: The control word passes through two synchroniser flops and one edge-detect flop. A configuration clock rise that completes a byte, applied between two clock edges, makes `byte_valid_o` high after the third following rising edge of `clk`, and not earlier.
- R3: On each rising edge of control bit 6, the value of control bit 5 is shifted in. The first bit received becomes bit 0 of the byte and the eighth becomes bit 7.
- R4: Every eighth captured bit produces exactly one cycle of `byte_valid_o`, together with the assembled byte on `byte_data_o`. `byte_data_o` keeps its value between pulses.
- R5: A rising edge of bit 6 is captured only when bit 7 is high in both the current and the previous synchronised sample. Clock edges that occur while bit 7 is low change neither the outputs nor the byte count.
- R6: A fall of bit 7 clears the bit counter and the partial byte, so the next byte is assembled only from bits received after the fall.
- R7: `byte_count_o` rises by one with each valid pulse and saturates at its all-ones value.
- R8: A rise of bit 7 starts a new load: it clears `byte_count_o` and `load_done_o`.
- R9: `load_done_o` is set when the synchronised control word first equals 0x10 while the bit counter is zero. It stays set, with the byte count frozen, until the next load start or reset.
- R10: If the end value 0x10 appears while a partial byte is pending, `load_done_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_i | input | CTRL_W | Asynchronous control word (bit 5 data, bit 6 config clock, bit 7 hold) |
| byte_valid_o | output | 1 | One-cycle pulse when a byte is complete |
| byte_data_o | output | BYTE_W | Last assembled byte |
| byte_count_o | output | CNT_W | Bytes delivered in the current load, saturating |
| load_done_o | output | 1 | End value seen on a byte boundary |

## Verification
The bench builds the block with `CNT_W` set to 4, so that the byte counter reaches its all-ones limit after fifteen bytes. This lets the saturation behaviour be observed within a short load. All other parameters keep their defaults: an 8-bit control word, 8-bit bytes and two synchroniser stages. With these defaults, the three-edge latency and the LSB-first ordering are the same as in production use.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    // Classification of what the hold line did between two samples.
    typedef enum logic [1:0] {
        HOLD_STEADY = 2'd0,
        HOLD_START  = 2'd1,
        HOLD_ABORT  = 2'd2
    } hold_ev_e;

    localparam int DEF_CTRL_W   = 8;
    localparam int DEF_BYTE_W   = 8;
    localparam int DEF_STAGES   = 2;

endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else begin
                stage_q[g] <= stage_d[g];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/cfgld_edge.sv
module cfgld_edge #(
    parameter int W        = 8,
    parameter int CLK_POS  = 6,
    parameter int HOLD_POS = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] prev_o,
    output logic         clk_rise_o,
    output logic         hold_rise_o,
    output logic         hold_fall_o
);

    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = cur_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign prev_o      = prev_q;
    assign clk_rise_o  = cur_i[CLK_POS]  & ~prev_q[CLK_POS];
    assign hold_rise_o = cur_i[HOLD_POS] & ~prev_q[HOLD_POS];
    assign hold_fall_o = ~cur_i[HOLD_POS] & prev_q[HOLD_POS];

endmodule

// File: rtl/cfgld_shift.sv
module cfgld_shift #(
    parameter int BYTE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear_i,
    input  logic                      capture_i,
    input  logic                      bit_i,
    output logic [$clog2(BYTE_W)-1:0] bit_cnt_o,
    output logic [BYTE_W-1:0]         byte_o,
    output logic                      last_o
);

    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [BIT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sr;
    } sh_t;

    sh_t sh_d, sh_q;
    logic [BYTE_W-1:0] merged;

    always_comb begin
        merged = {bit_i, sh_q.sr[BYTE_W-1:1]};
        sh_d   = sh_q;
        if (clear_i) begin
            sh_d.cnt = '0;
            sh_d.sr  = '0;
        end else if (capture_i) begin
            sh_d.sr  = merged;
            sh_d.cnt = (sh_q.cnt == LAST_IDX) ? '0 : sh_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign bit_cnt_o = sh_q.cnt;
    assign byte_o    = merged;
    assign last_o    = capture_i && (sh_q.cnt == LAST_IDX);

endmodule

// File: rtl/cfgld_top.sv
module cfgld_top
    import cfgld_pkg::*;
#(
    parameter int                CTRL_W      = DEF_CTRL_W,
    parameter int                BYTE_W      = DEF_BYTE_W,
    parameter int                CNT_W       = 16,
    parameter int                SYNC_STAGES = DEF_STAGES,
    parameter int                DATA_POS    = 5,
    parameter int                CLK_POS     = 6,
    parameter int                HOLD_POS    = 7,
    parameter logic [CTRL_W-1:0] END_MARK    = CTRL_W'(8'h10)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctl_i,
    output logic              byte_valid_o,
    output logic [BYTE_W-1:0] byte_data_o,
    output logic [CNT_W-1:0]  byte_count_o,
    output logic              load_done_o
);

    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
        logic [CNT_W-1:0]  count;
        logic              done;
    } st_t;

    logic [CTRL_W-1:0] ctl_s, ctl_p;
    logic              clk_rise, hold_rise, hold_fall;
    logic [BIT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] byte_new;
    logic              byte_last;
    logic              capture, clear_sh, marker_hit;
    hold_ev_e          hold_ev;
    st_t               st_d, st_q;

    cfgld_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ctl_i),
        .dout (ctl_s)
    );

    cfgld_edge #(.W(CTRL_W), .CLK_POS(CLK_POS), .HOLD_POS(HOLD_POS)) i_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_i      (ctl_s),
        .prev_o     (ctl_p),
        .clk_rise_o (clk_rise),
        .hold_rise_o(hold_rise),
        .hold_fall_o(hold_fall)
    );

    always_comb begin
        if (hold_rise)      hold_ev = HOLD_START;
        else if (hold_fall) hold_ev = HOLD_ABORT;
        else                hold_ev = HOLD_STEADY;
        capture  = ctl_s[HOLD_POS] && ctl_p[HOLD_POS] && clk_rise;
        clear_sh = (hold_ev != HOLD_STEADY);
    end

    cfgld_shift #(.BYTE_W(BYTE_W)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear_sh),
        .capture_i(capture),
        .bit_i    (ctl_s[DATA_POS]),
        .bit_cnt_o(bit_cnt),
        .byte_o   (byte_new),
        .last_o   (byte_last)
    );

    always_comb begin
        marker_hit = (ctl_s == END_MARK) && (ctl_p != END_MARK) && (bit_cnt == '0);
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (hold_ev == HOLD_START) begin
            st_d.count = '0;
            st_d.done  = 1'b0;
        end
        if (byte_last) begin
            st_d.valid = 1'b1;
            st_d.data  = byte_new;
            if (st_q.count != CNT_MAX) begin
                st_d.count = st_q.count + 1'b1;
            end
        end
        if (marker_hit) begin
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_valid_o = st_q.valid;
    assign byte_data_o  = st_q.data;
    assign byte_count_o = st_q.count;
    assign load_done_o  = st_q.done;

endmodule

// File: rtl/cfgld_checker.sv
module cfgld_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_valid_o,
    input logic [CNT_W-1:0] byte_count_o,
    input logic             load_done_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o |=> !byte_valid_o); // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_o && $past(byte_count_o) != CNT_MAX)
            |-> byte_count_o == $past(byte_count_o) + 1'b1); // R7

    AST_COUNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid_o && $past(byte_count_o) == CNT_MAX)
            |-> byte_count_o == CNT_MAX); // R7

    AST_COUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_valid_o && byte_count_o != '0)
            |-> byte_count_o == $past(byte_count_o)); // R8

    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done_o && $past(load_done_o))
            |-> (byte_count_o == $past(byte_count_o) && !byte_valid_o)); // R9

endmodule

bind cfgld_top cfgld_checker #(.CNT_W(CNT_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_valid_o(byte_valid_o),
    .byte_count_o(byte_count_o),
    .load_done_o (load_done_o)
);

// File: tb/test_cfgld_top.sv
module test_cfgld_top;

    localparam int TB_CNT_W = 4;
    localparam int TB_MAX   = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ctl = 8'h00;
    logic       byte_valid_o;
    logic [7:0] byte_data_o;
    logic [TB_CNT_W-1:0] byte_count_o;
    logic       load_done_o;

    int checks = 0;
    int errors = 0;
    int valid_seen = 0;
    bit finished = 0;

    // reference model state
    int  d1 = 0, d2 = 0, d3 = 0;
    int  m_bits = 0, m_shift = 0, m_data = 0, m_cnt = 0;
    bit  m_valid = 0, m_done = 0;

    always #10 clk = ~clk;

    cfgld_top #(.CNT_W(TB_CNT_W)) i_cfgld_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_i       (ctl),
        .byte_valid_o(byte_valid_o),
        .byte_data_o (byte_data_o),
        .byte_count_o(byte_count_o),
        .load_done_o (load_done_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Behavioural reference: delayed samples of the control word.
    always @(posedge clk) begin
        if (!rst_n) begin
            d1 = 0; d2 = 0; d3 = 0;
            m_bits = 0; m_shift = 0; m_data = 0; m_cnt = 0;
            m_valid = 0; m_done = 0;
        end else begin
            int s, p, bits_before;
            s = d2; p = d3; bits_before = m_bits;
            m_valid = 0;
            if (s[7] && !p[7]) begin
                m_bits = 0; m_shift = 0; m_cnt = 0; m_done = 0;
            end else if (!s[7] && p[7]) begin
                m_bits = 0; m_shift = 0;
            end
            if (s[7] && p[7] && s[6] && !p[6]) begin
                m_shift = ((m_shift >> 1) | (s[5] << 7)) & 8'hFF;
                m_bits++;
                if (m_bits == 8) begin
                    m_valid = 1;
                    m_data  = m_shift;
                    if (m_cnt < TB_MAX) m_cnt++;
                    m_bits  = 0;
                end
            end
            if (s == 8'h10 && p != 8'h10 && bits_before == 0) m_done = 1;
            d3 = d2; d2 = d1; d1 = ctl;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid_o) valid_seen++;
            check(byte_valid_o == m_valid, "R4 valid", byte_valid_o, m_valid);
            check(byte_data_o == m_data[7:0], "R3 data", byte_data_o, m_data);
            check(byte_count_o == m_cnt[TB_CNT_W-1:0], "R7 count", byte_count_o, m_cnt);
            check(load_done_o == m_done, "R9 done", load_done_o, m_done);
        end
    end

    task automatic put(input logic [7:0] v, input int n);
        @(negedge clk);
        ctl = v;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        put(8'h80 | (8'(b) << 5), 3);
        put(8'hC0 | (8'(b) << 5), 3);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0h expected %0h", 1, 0);
        finish_run();
    end

    initial begin
        int vs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        check(byte_valid_o == 0 && byte_data_o == 0 && byte_count_o == 0 && load_done_o == 0,
              "R1 reset outputs", {byte_valid_o, byte_data_o, byte_count_o, load_done_o}, 0);

        put(8'h80, 4);
        // R2: latency of a completing clock rise, byte 0x81
        for (int i = 0; i < 7; i++) send_bit(i == 0);
        put(8'hA0, 3);
        @(negedge clk); ctl = 8'hE0;
        @(negedge clk);
        check(byte_valid_o == 0, "R2 early edge 1", byte_valid_o, 0);
        @(negedge clk);
        check(byte_valid_o == 0, "R2 early edge 2", byte_valid_o, 0);
        @(negedge clk);
        check(byte_valid_o == 1, "R2 third edge", byte_valid_o, 1);
        check(byte_data_o == 8'h81, "R3 lsb first", byte_data_o, 8'h81);
        put(8'hE0, 3);

        send_byte(8'hA5);
        send_byte(8'h3C);
        put(8'h80, 4);
        check(byte_data_o == 8'h3C, "R4 data held", byte_data_o, 8'h3C);
        check(byte_count_o == 3, "R7 count three", byte_count_o, 3);

        put(8'h10, 4);
        check(load_done_o == 1, "R9 done set", load_done_o, 1);
        check(byte_count_o == 3, "R9 count frozen", byte_count_o, 3);

        // R5: clock edges with hold low are ignored
        vs = valid_seen;
        for (int i = 0; i < 10; i++) begin
            put(8'h20, 3);
            put(8'h60, 3);
        end
        put(8'h00, 4);
        check(valid_seen == vs, "R5 no pulses", valid_seen, vs);
        check(byte_count_o == 3, "R5 count kept", byte_count_o, 3);

        // R8: a new load clears count and done
        put(8'h80, 4);
        check(load_done_o == 0, "R8 done cleared", load_done_o, 0);
        check(byte_count_o == 0, "R8 count cleared", byte_count_o, 0);

        // R6: partial byte discarded on hold fall
        send_bit(1); send_bit(1); send_bit(1);
        put(8'h00, 4);
        put(8'h80, 4);
        send_byte(8'h5A);
        put(8'h80, 4);
        check(byte_data_o == 8'h5A, "R6 fresh byte", byte_data_o, 8'h5A);
        check(byte_count_o == 1, "R6 count", byte_count_o, 1);

        // R10: end value with partial byte pending
        send_bit(0); send_bit(1); send_bit(0);
        put(8'h10, 5);
        check(load_done_o == 0, "R10 no done", load_done_o, 0);

        // R7: saturation
        put(8'h00, 3);
        put(8'h80, 4);
        for (int i = 0; i < 17; i++) send_byte(8'(i * 7 + 3));
        put(8'h80, 4);
        check(byte_count_o == TB_MAX, "R7 saturated", byte_count_o, TB_MAX);
        put(8'h10, 4);
        check(load_done_o == 1, "R9 done after saturation", load_done_o, 1);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule